// File: doc/BRIEF.md
# Back-Current Hiccup Retry Timer

This block watches a regulator output that an external line at a higher voltage can drive backwards. An analog comparator outside the block raises one flag whenever reverse current through the low-side switch is above its threshold. The block accepts the flag as a real fault only when it stays high without a break for a qualification window. Once the fault qualifies, the block turns the output off for a fixed lockout interval and keeps a status bit high for that whole interval. It then turns the output back on and starts qualifying again. A back-drive that persists therefore produces a steady hiccup of short on phases and long off phases. When the back-drive goes away the output stays on, because nothing latches.

The two durations are parameters given in clock cycles, so a system integrator derives them from the clock frequency. At a 50 MHz clock, for example, a 2 ms window is 100000 cycles and a 50 ms lockout is 2500000 cycles. A supervising enable input turns supervision on and off. When it is low, the output stays on and all timing state is held cleared.

Top module: `bcf_retry_timer`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the next outputs are `out_en`=1 and `fault_off`=0, and both counters clear.
- R2: With `en`=1 and the output on, the block trips on the QUAL_CYCLES-th consecutive edge at which `rev_flag`=1. `out_en` goes low and `fault_off` goes high right after that edge. Any edge with `rev_flag`=0 restarts the count, so QUAL_CYCLES-1 consecutive samples never trip.
- R3: After a trip, `out_en` stays low for exactly OFF_CYCLES clock cycles and then returns high, provided `en` stays high and no reset occurs.
- R4: `fault_off` is high exactly in the cycles in which the lockout holds `out_en` low, and it is low at all other times.
- R5: After a lockout ends, qualification starts again from zero. With `rev_flag` held at 1, the output cycles with QUAL_CYCLES cycles on and OFF_CYCLES cycles off.
- R6: Once `rev_flag` stays 0, the output remains on indefinitely after the current lockout, with no latch-off.
- R7: `rev_flag` values sampled during a lockout do not shorten or extend it, and they do not count towards the next qualification.
- R8: An edge with `en`=0 makes `out_en`=1 and `fault_off`=0 next, including in the middle of a lockout, and it clears the qualification count. While `en`=0, `rev_flag` never trips the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Supervision enable, active high |
| rev_flag | input | 1 | Reverse-current comparator flag, high when over threshold |
| out_en | output | 1 | Regulator output enable, high = output on |
| fault_off | output | 1 | Back-current fault status, high during the lockout |

## Verification
The assertions check three things on every cycle. Every rising edge of the status bit is preceded by exactly QUAL_CYCLES-1 earlier consecutive qualifying samples plus the tripping one. Every undisturbed lockout ends after exactly OFF_CYCLES cycles. A low enable always lands the block in the on state. The rest can only be shown by the bench's scenarios, because it needs a history of stimulus: near-miss pulses that never trip, the repeated hiccup period under a stuck flag, flag activity ignored during lockout, and the output staying on after the fault is removed.

// File: rtl/bcf_retry_timer.sv
module bcf_retry_timer #(
  parameter int unsigned QUAL_CYCLES = 100000,
  parameter int unsigned OFF_CYCLES  = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rev_flag,
  output logic out_en,
  output logic fault_off
);

  localparam int unsigned QW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
  localparam int unsigned OW = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1;
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYCLES - 1);
  localparam logic [OW-1:0] OFF_LAST  = OW'(OFF_CYCLES - 1);

  logic          lock_q;
  logic [QW-1:0] qual_cnt;
  logic [OW-1:0] off_cnt;

  wire qual_hit = rev_flag && (qual_cnt == QUAL_LAST);
  wire off_done = (off_cnt == OFF_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lock_q   <= 1'b0;
      qual_cnt <= '0;
      off_cnt  <= '0;
    end else if (lock_q) begin
      qual_cnt <= '0;
      if (off_done) begin
        lock_q  <= 1'b0;
        off_cnt <= '0;
      end else begin
        off_cnt <= off_cnt + 1'b1;
      end
    end else if (qual_hit) begin
      lock_q   <= 1'b1;
      qual_cnt <= '0;
    end else if (rev_flag) begin
      qual_cnt <= qual_cnt + 1'b1;
    end else begin
      qual_cnt <= '0;
    end
  end

  assign out_en    = !lock_q;
  assign fault_off = lock_q;

endmodule

// File: rtl/bcf_retry_timer_chk.sv
module bcf_retry_timer_chk #(
  parameter int unsigned QUAL_CYCLES = 100000,
  parameter int unsigned OFF_CYCLES  = 2500000
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic rev_flag,
  input logic out_en,
  input logic fault_off
);

  int unsigned run_len;
  int unsigned off_len;

  always_ff @(posedge clk) begin
    if (rst || !en || !rev_flag || fault_off) run_len <= 0;
    else if (run_len < QUAL_CYCLES) run_len <= run_len + 1;
    if (rst || !fault_off) off_len <= 0;
    else off_len <= off_len + 1;
  end

  // R2: a trip needs QUAL_CYCLES-1 earlier consecutive samples plus the current one
  assert_trip_window_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(fault_off) && !$past(rst)) |-> ($past(rev_flag) && $past(run_len) == QUAL_CYCLES - 1));

  // R3: an undisturbed lockout lasts exactly OFF_CYCLES cycles
  assert_off_length_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(fault_off) && $past(en) && !$past(rst)) |-> ($past(off_len) == OFF_CYCLES - 1));

  // R3: the lockout never overruns
  assert_off_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fault_off |-> (off_len < OFF_CYCLES));

  // R8: a low enable always leaves the output on with status clear
  assert_disable_on_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (out_en && !fault_off));

endmodule

bind bcf_retry_timer bcf_retry_timer_chk #(
  .QUAL_CYCLES(QUAL_CYCLES),
  .OFF_CYCLES (OFF_CYCLES)
) u_chk (.*);

// File: tb/bcf_retry_timer_bench.sv
module bcf_retry_timer_bench;
  localparam int unsigned QC = 8;
  localparam int unsigned OC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic rev_flag = 1'b0;
  logic out_en, fault_off;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  bcf_retry_timer #(.QUAL_CYCLES(QC), .OFF_CYCLES(OC)) u_bcf_retry_timer (
    .clk(clk), .rst(rst), .en(en), .rev_flag(rev_flag),
    .out_en(out_en), .fault_off(fault_off)
  );

  // reference model built from the requirements
  bit m_lock = 1'b0;
  int m_q = 0;
  int m_o = 0;

  function automatic void model_step(bit r, bit e, bit f);
    if (r || !e) begin
      m_lock = 1'b0; m_q = 0; m_o = 0;
    end else if (m_lock) begin
      m_q = 0;
      m_o++;
      if (m_o == OC) begin m_lock = 1'b0; m_o = 0; end
    end else if (f) begin
      m_q++;
      if (m_q == QC) begin m_lock = 1'b1; m_q = 0; end
    end else begin
      m_q = 0;
    end
  endfunction

  always @(posedge clk) model_step(rst, en, rev_flag);

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drv(bit r, bit e, bit f);
    @(negedge clk);
    check(out_en === !m_lock, cur_req, "out_en", int'(out_en), int'(!m_lock));
    check(fault_off === m_lock, "R4", "fault_off", int'(fault_off), int'(m_lock));
    rst = r; en = e; rev_flag = f;
  endtask

  task automatic measure(bit f, bit lvl, output int n);
    n = 1;
    forever begin
      drv(1'b0, 1'b1, f);
      if (out_en == lvl) n++;
      else break;
    end
  endtask

  initial begin
    int n;
    bit stayed;
    void'($urandom(32'h5eed_1234));
    repeat (3) drv(1'b1, 1'b1, 1'b1);
    drv(1'b0, 1'b1, 1'b0);
    check(out_en === 1'b1 && fault_off === 1'b0, "R1", "reset state", int'({out_en, fault_off}), 2);

    cur_req = "R2";
    stayed = 1'b1;
    repeat (5) begin
      repeat (QC - 1) begin drv(1'b0, 1'b1, 1'b1); if (!out_en) stayed = 1'b0; end
      drv(1'b0, 1'b1, 1'b0); if (!out_en) stayed = 1'b0;
    end
    drv(1'b0, 1'b1, 1'b0); if (!out_en) stayed = 1'b0;
    check(stayed, "R2", "near-miss pulses keep output on", int'(stayed), 1);
    repeat (QC) drv(1'b0, 1'b1, 1'b1);
    drv(1'b0, 1'b1, 1'b0);
    check(out_en === 1'b0 && fault_off === 1'b1, "R2", "trip on QC-th sample", int'(out_en), 0);

    cur_req = "R7";
    n = 1;
    forever begin
      drv(1'b0, 1'b1, 1'($urandom_range(0, 1)));
      if (!out_en) n++; else break;
    end
    check(n == OC, "R7", "off length with flag noise", n, OC);

    cur_req = "R3";
    repeat (3) drv(1'b0, 1'b1, 1'b0);
    repeat (QC) drv(1'b0, 1'b1, 1'b1);
    drv(1'b0, 1'b1, 1'b0);
    measure(1'b0, 1'b0, n);
    check(n == OC, "R3", "off length", n, OC);

    cur_req = "R5";
    repeat (QC) drv(1'b0, 1'b1, 1'b1);
    drv(1'b0, 1'b1, 1'b1);
    check(out_en === 1'b0, "R5", "stuck flag trips", int'(out_en), 0);
    for (int k = 0; k < 3; k++) begin
      measure(1'b1, 1'b0, n);
      check(n == OC, "R5", "hiccup off phase", n, OC);
      measure(1'b1, 1'b1, n);
      check(n == QC, "R5", "hiccup on phase", n, QC);
    end

    cur_req = "R6";
    measure(1'b0, 1'b0, n);
    stayed = 1'b1;
    repeat (5 * (QC + OC)) begin drv(1'b0, 1'b1, 1'b0); if (!out_en || fault_off) stayed = 1'b0; end
    check(stayed, "R6", "stays on after fault removed", int'(stayed), 1);

    cur_req = "R8";
    repeat (QC - 2) drv(1'b0, 1'b1, 1'b1);
    drv(1'b0, 1'b0, 1'b1);
    stayed = 1'b1;
    repeat (QC - 1) begin drv(1'b0, 1'b1, 1'b1); if (!out_en) stayed = 1'b0; end
    drv(1'b0, 1'b1, 1'b0); if (!out_en) stayed = 1'b0;
    check(stayed, "R8", "enable low clears qualification", int'(stayed), 1);
    repeat (3 * QC) begin drv(1'b0, 1'b0, 1'b1); if (!out_en) stayed = 1'b0; end
    check(stayed, "R8", "no trip while disabled", int'(stayed), 1);
    repeat (QC) drv(1'b0, 1'b1, 1'b1);
    drv(1'b0, 1'b1, 1'b1);
    drv(1'b0, 1'b0, 1'b1);
    drv(1'b0, 1'b1, 1'b0);
    check(out_en === 1'b1 && fault_off === 1'b0, "R8", "disable mid-lockout", int'(out_en), 1);

    cur_req = "R1";
    repeat (QC + 2) drv(1'b0, 1'b1, 1'b1);
    drv(1'b1, 1'b1, 1'b1);
    drv(1'b0, 1'b1, 1'b0);
    check(out_en === 1'b1 && fault_off === 1'b0, "R1", "reset mid-lockout", int'(out_en), 1);

    cur_req = "R2 R3 R5 random";
    begin
      bit f = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 9) == 0) f = ~f;
        drv(($urandom_range(0, 499) == 0), ($urandom_range(0, 199) != 0), f);
      end
    end
    drv(1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule